// File: doc/BRIEF.md
# Programmable Down-Counting Timer Bank

This block holds a row of identical countdown timer channels behind a plain 32-bit register bus. A single-cycle `tick` strobe from a reference clock divider drives every counter. Software arms a channel by writing one word that carries the run enable, the repeat-mode flag and a 29-bit count. The channel then counts down once per tick. When it expires it sets a sticky pending flag, and that flag drives the channel's own interrupt line.

In repeat mode the channel reloads its programmed count on expiry and keeps running. In single mode it drops its enable, parks the counter at zero and waits. A second register per channel shows the live count and the pending flag. Writing a word with the clear bit set to that register acknowledges the interrupt. Channels sit at an 8-byte stride: address bit 2 selects the register within a channel and the bits above it select the channel.

Each channel is a three-state machine. `ST_IDLE` means stopped. `ST_RUN_ONCE` means counting in single mode. `ST_RUN_LOOP` means counting in repeat mode. The transitions are:
- arm_once (IDLE or either run state to RUN_ONCE): a trigger write with enable set and repeat clear.
- arm_loop (to RUN_LOOP): a trigger write with enable and repeat both set.
- halt (either run state to IDLE): a trigger write with enable clear.
- expire_once (RUN_ONCE to IDLE): the count is zero when a tick arrives.
- expire_loop (RUN_LOOP to RUN_LOOP): the count is zero when a tick arrives, and the counter reloads.

Top module: `tmr_bank`

## Requirements
- R1: After reset every irq line is low and both registers of every channel read 0.
- R2: The trigger register sits at channel offset 0x0 and uses these fields: bit 31 enable, bit 30 repeat mode, bits 28:0 count. Reading it returns the current enable, the stored repeat bit and the stored count. Bit 29 and a written bit 29 are ignored and read 0.
- R3: A trigger write with enable set and count N makes the channel expire on the (N+1)th tick after the write. The irq line rises in the cycle after that tick. Cycles without a tick leave the count unchanged.
- R4: In repeat mode the counter reloads N on expiry, so the next expiry comes N+1 ticks later.
- R5: In single mode, expiry clears the enable bit (trigger register bit 31 reads 0), holds the count at 0 and causes no further expiry.
- R6: Writing all zeros to the trigger register stops the channel. The count then reads 0 and no expiry follows, whatever ticks arrive.
- R7: A write to channel offset 0x4 with bit 30 set clears the pending flag. A write there with bit 30 clear has no effect.
- R8: The pending flag, and with it irq, stays high until cleared, even after the channel is disabled.
- R9: A trigger write to a running channel restarts the countdown from the new count. If the write and a tick land in the same cycle, the write wins and the tick is dropped.
- R10: Reading channel offset 0x4 returns the live count in bits 28:0 and the pending flag in bit 30. All other bits read 0.
- R11: Channel k answers at byte address 8k and has its own irq bit k. Channels do not affect each other. Addresses beyond the last channel read 0 and ignore writes.
- R12: If a clear write and an expiry fall in the same cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick strobe, one cycle wide |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | NUM_CH | Level interrupt, one bit per channel |

## Verification
The bench counts ticks to the exact edge of expiry for zero and non-zero counts. A design that expires one tick early or late, as N instead of N+1 counting would do, raises irq at the wrong check. It collides a trigger write with a tick, and a clear write with an expiry. A design with the wrong priority would show a decremented count or a lost interrupt. It disables a channel with irq pending and writes offset 0x4 without the clear bit, which catches a design that drops the flag on disable or clears it on any write. It arms two channels at once and probes an address past the last channel, which exposes a decoder that aliases or leaks writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W    = 32;
    localparam int BIT_EN   = 31;
    localparam int BIT_REP  = 30;
    localparam int BIT_CLR  = 30;
    localparam int BIT_PEND = 30;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN_ONCE = 2'd1,
        ST_RUN_LOOP = 2'd2
    } run_state_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] wr_trig,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic              hit,
    output logic [IDX_W-1:0]  ch_idx,
    output logic              reg_sel
);
    logic unused_addr_lsb;
    assign unused_addr_lsb = ^bus_addr[1:0];

    assign ch_idx  = bus_addr[ADDR_W-1:3];
    assign reg_sel = bus_addr[2];
    assign hit     = ({1'b0, ch_idx} < (IDX_W+1)'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        logic match;
        assign match      = bus_sel && bus_wr && (ch_idx == IDX_W'(g));
        assign wr_trig[g] = match && !reg_sel;
        assign wr_ctrl[g] = match &&  reg_sel;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_trig,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] trig_rd,
    output logic [BUS_W-1:0] stat_rd,
    output logic             irq
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             rep_q;
    logic             pend_q;
    logic             running;
    logic             expire;
    logic             clr_req;

    logic unused_wdata;
    assign unused_wdata = ^wdata[29];

    assign running = (state_q != ST_IDLE);
    // a trigger write in the same cycle beats the tick
    assign expire  = tick && running && !wr_trig && (cnt_q == '0);
    assign clr_req = wr_ctrl && wdata[BIT_CLR];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_trig && wdata[BIT_EN])
                    state_d = wdata[BIT_REP] ? ST_RUN_LOOP : ST_RUN_ONCE;
            end
            ST_RUN_ONCE: begin
                if (wr_trig)
                    state_d = !wdata[BIT_EN] ? ST_IDLE :
                              (wdata[BIT_REP] ? ST_RUN_LOOP : ST_RUN_ONCE);
                else if (expire)
                    state_d = ST_IDLE;
            end
            ST_RUN_LOOP: begin
                if (wr_trig)
                    state_d = !wdata[BIT_EN] ? ST_IDLE :
                              (wdata[BIT_REP] ? ST_RUN_LOOP : ST_RUN_ONCE);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter, reload value and mode bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            rep_q    <= 1'b0;
        end else if (wr_trig) begin
            cnt_q    <= wdata[CNT_W-1:0];
            reload_q <= wdata[CNT_W-1:0];
            rep_q    <= wdata[BIT_REP];
        end else if (tick && running) begin
            if (cnt_q == '0)
                cnt_q <= (state_q == ST_RUN_LOOP) ? reload_q : '0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // pending flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (expire)  pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    // outputs
    always_comb begin
        trig_rd                = '0;
        trig_rd[BIT_EN]        = running;
        trig_rd[BIT_REP]       = rep_q;
        trig_rd[CNT_W-1:0]     = reload_q;
        stat_rd                = '0;
        stat_rd[BIT_PEND]      = pend_q;
        stat_rd[CNT_W-1:0]     = cnt_q;
        irq                    = pend_q;
    end

    // R5
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_ONCE && expire) |=> (state_q == ST_IDLE && cnt_q == '0));

    // R4
    loop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_LOOP && expire) |=> (cnt_q == $past(reload_q)));

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_req) |=> pend_q);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_trig) |=> $stable(cnt_q));

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(running));

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && clr_req) |=> pend_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int IDX_W = ADDR_W - 3;

    logic [NUM_CH-1:0] wr_trig;
    logic [NUM_CH-1:0] wr_ctrl;
    logic              hit;
    logic [IDX_W-1:0]  ch_idx;
    logic              reg_sel;
    logic [BUS_W-1:0]  trig_rd [NUM_CH];
    logic [BUS_W-1:0]  stat_rd [NUM_CH];

    tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_trig (wr_trig),
        .wr_ctrl (wr_ctrl),
        .hit     (hit),
        .ch_idx  (ch_idx),
        .reg_sel (reg_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wr_trig(wr_trig[g]),
            .wr_ctrl(wr_ctrl[g]),
            .wdata  (bus_wdata),
            .trig_rd(trig_rd[g]),
            .stat_rd(stat_rd[g]),
            .irq    (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && ch_idx == IDX_W'(i))
                bus_rdata = reg_sel ? stat_rd[i] : trig_rd[i];
        end
    end

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_trig, wr_ctrl}));

    // R11
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> ({wr_trig, wr_ctrl} == '0));
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    tmr_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] REP = 32'h4000_0000;
    localparam logic [31:0] CLR = 32'h4000_0000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq", 32'(irq), 32'h0);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ADDR_W'(c*8), d);     check("R1 trig", d, 32'h0);
            rd(ADDR_W'(c*8 + 4), d); check("R1 stat", d, 32'h0);
        end
    endtask

    task automatic t_layout();
        logic [31:0] d;
        do_reset();
        wr(8'h00, 32'hE000_0005, 1'b0);
        rd(8'h00, d); check("R2 readback", d, 32'hC000_0005);
        rd(8'h04, d); check("R10 stat", d, 32'h0000_0005);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        do_reset();
        wr(8'h00, EN | 32'd3, 1'b0);
        repeat (5) @(negedge clk);
        rd(8'h04, d); check("R3 no tick no change", d, 32'd3);
        ticks(3);
        check("R3 irq before N+1", 32'(irq), 32'h0);
        rd(8'h04, d); check("R3 count", d, 32'd0);
        ticks(1);
        check("R3 irq at N+1", 32'(irq), 32'h1);
        rd(8'h00, d); check("R5 enable cleared", d, 32'd3);
        rd(8'h04, d); check("R5 parked", d, CLR);
        wr(8'h04, CLR, 1'b0);
        ticks(4);
        check("R5 no re-expiry", 32'(irq), 32'h0);
        rd(8'h04, d); check("R5 held zero", d, 32'h0);
        wr(8'h00, EN, 1'b0);
        ticks(1);
        check("R3 N=0 one tick", 32'(irq), 32'h1);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        do_reset();
        wr(8'h00, EN | REP | 32'd2, 1'b0);
        ticks(3);
        check("R4 first expiry", 32'(irq), 32'h1);
        rd(8'h04, d); check("R10 reload+pend", d, CLR | 32'd2);
        wr(8'h04, CLR, 1'b0);
        ticks(2);
        check("R4 not yet", 32'(irq), 32'h0);
        rd(8'h04, d); check("R4 count", d, 32'd0);
        ticks(1);
        check("R4 second expiry", 32'(irq), 32'h1);
        rd(8'h00, d); check("R4 still enabled", d, EN | REP | 32'd2);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        do_reset();
        wr(8'h00, EN | 32'd5, 1'b0);
        ticks(2);
        rd(8'h04, d); check("R6 mid count", d, 32'd3);
        wr(8'h00, 32'h0, 1'b0);
        rd(8'h00, d); check("R6 trig zero", d, 32'h0);
        ticks(8);
        check("R6 no expiry", 32'(irq), 32'h0);
        rd(8'h04, d); check("R6 count zero", d, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        do_reset();
        wr(8'h00, EN, 1'b0);
        ticks(1);
        check("R8 set", 32'(irq), 32'h1);
        wr(8'h00, 32'h0, 1'b0);
        check("R8 kept after disable", 32'(irq), 32'h1);
        wr(8'h04, 32'hBFFF_FFFF, 1'b0);
        check("R7 no clear without bit30", 32'(irq), 32'h1);
        rd(8'h04, d); check("R7 pend kept", d, CLR);
        wr(8'h04, CLR, 1'b0);
        check("R7 cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        do_reset();
        wr(8'h00, EN | 32'd10, 1'b0);
        ticks(3);
        rd(8'h04, d); check("R9 before rewrite", d, 32'd7);
        wr(8'h00, EN | 32'd1, 1'b0);
        rd(8'h04, d); check("R9 reloaded", d, 32'd1);
        ticks(1);
        check("R9 not yet", 32'(irq), 32'h0);
        ticks(1);
        check("R9 expiry", 32'(irq), 32'h1);
        wr(8'h00, EN | 32'd4, 1'b1);
        rd(8'h04, d); check("R9 write beats tick", d, CLR | 32'd4);
    endtask

    task automatic t_collide();
        do_reset();
        wr(8'h00, EN | REP, 1'b0);
        ticks(1);
        check("R12 setup", 32'(irq), 32'h1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = CLR; tick = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        check("R12 set wins", 32'(irq), 32'h1);
        wr(8'h04, CLR, 1'b0);
        check("R12 then clears", 32'(irq), 32'h0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        do_reset();
        wr(8'h08, EN | 32'd1, 1'b0);
        wr(8'h18, EN | REP | 32'd3, 1'b0);
        wr(8'h20, EN, 1'b0);
        ticks(2);
        check("R11 own irq", 32'(irq), 32'h2);
        rd(8'h00, d); check("R11 ch0 untouched", d, 32'h0);
        rd(8'h1C, d); check("R11 ch3 count", d, 32'd1);
        rd(8'h20, d); check("R11 out of range", d, 32'h0);
        ticks(2);
        check("R11 both irq", 32'(irq), 32'hA);
        wr(8'h0C, CLR, 1'b0);
        check("R11 clear only ch1", 32'(irq), 32'h8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        t_reset();
        t_layout();
        t_oneshot();
        t_periodic();
        t_stop();
        t_sticky();
        t_restart();
        t_collide();
        t_multi();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule